// File: doc/BRIEF.md
# Stack-Machine Effective Address Generator

This block turns a 16-bit memory-reference instruction word into the address the instruction touches. The low ten bits hold a prefix-coded mode field: the prefix picks a base register (program counter, data base, frame marker or stack pointer) and a direction, and the bits left after the prefix form an unsigned displacement. The displacement therefore narrows as the prefix grows longer. Bit 11 asks for the index register to be added. Bit 10 asks for one level of indirection through a memory read port.

The caller presents the instruction and pulses `start` while the block is idle. A direct reference returns its address one cycle later. An indirect reference first issues a read at the computed address and holds it until the data returns. The returned word is then used as an offset from the data base, for data-class modes, or from the program base, for code-class modes. Every result is checked against the limits of its class and flagged as a fault if it falls outside them.

Top module: `ea_gen`

## Requirements
- R1: After reset `ea_valid`, `ea_fault`, `rd_req` and `busy` are 0. Opcode bits 15-12 have no effect on the address.
- R2: Mode bits [9:8]=00 give PC + instr[7:0], and [9:8]=01 give PC - instr[7:0]. Both are code-class modes.
- R3: Mode bits [9:8]=10 give DB + instr[7:0]. This is a data-class mode.
- R4: Mode bits [9:7]=110 give Q + instr[6:0], and [9:6]=1110 give Q - instr[5:0]. Both are data-class modes.
- R5: Mode bits [9:6]=1111 give SP - instr[5:0]. This is a data-class mode.
- R6: When bit 11 is 1, the index input is added modulo 2^16 to the mode result. This happens before any indirection, so the indexed value is also the read address.
- R7: A direct reference (bit 10 = 0) accepted in cycle N gives `ea_valid`=1 and `ea` in cycle N+1 only. `ea` then holds its value until the next result.
- R8: An indirect reference (bit 10 = 1) raises `rd_req` in the cycle after acceptance, with `rd_addr` set to the computed address. Both stay unchanged until `rd_valid`. In the cycle after `rd_valid`, `ea_valid`=1 and `ea` = DB + `rd_data` for data-class modes, or PB + `rd_data` for code-class modes.
- R9: For a data-class mode, `ea_fault` is 1 together with `ea_valid` exactly when the final address is below DB or above SL (unsigned compare).
- R10: For a code-class mode, `ea_fault` is 1 together with `ea_valid` exactly when the final address is below PB or above PL (unsigned compare).
- R11: A `start` that arrives while `busy` is 1 is ignored. It changes neither the pending read nor the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept `instr` when idle |
| instr | input | 16 | Memory-reference instruction word |
| pc | input | W | Program counter |
| pb | input | W | Program base (lower code limit) |
| pl | input | W | Program limit (upper code limit) |
| db | input | W | Data base (lower data limit) |
| sl | input | W | Stack limit (upper data limit) |
| q | input | W | Frame marker |
| sp | input | W | Stack pointer |
| xr | input | W | Index register |
| busy | output | 1 | Indirect read outstanding |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | W | Memory read address |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | W | Returned read word |
| ea_valid | output | 1 | Result strobe |
| ea_fault | output | 1 | Result is outside its class limits |
| ea | output | W | Effective address |

## Verification
The assertions take for granted that `rd_valid` is asserted only while `rd_req` is high. They also assume the register inputs stay stable from acceptance to result, because the final sum and the limit check use their live values. The bench therefore loads the register inputs once, and it raises `rd_valid` only after it has seen `rd_req` for a few cycles. It sends the one `start` that arrives while busy in the middle of a pending read. That start is placed so the assertions and the bench checks can both confirm it has no effect.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [15:0]  instr,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] pb,
  input  logic [W-1:0] pl,
  input  logic [W-1:0] db,
  input  logic [W-1:0] sl,
  input  logic [W-1:0] q,
  input  logic [W-1:0] sp,
  input  logic [W-1:0] xr,
  output logic         busy,
  output logic         rd_req,
  output logic [W-1:0] rd_addr,
  input  logic         rd_valid,
  input  logic [W-1:0] rd_data,
  output logic         ea_valid,
  output logic         ea_fault,
  output logic [W-1:0] ea
);

  typedef enum logic {S_IDLE, S_WAIT} st_t;
  st_t st;

  logic [9:0]   m;
  logic [W-1:0] base, disp, addr, fin;
  logic         neg, code, code_q;

  assign m = instr[9:0];

  always_comb begin
    neg  = 1'b0;
    code = 1'b0;
    disp = {{(W-8){1'b0}}, m[7:0]};
    if (!m[9]) begin
      base = pc;
      neg  = m[8];
      code = 1'b1;
    end else if (!m[8]) begin
      base = db;
    end else if (!m[7]) begin
      base = q;
      disp = {{(W-7){1'b0}}, m[6:0]};
    end else if (!m[6]) begin
      base = q;
      neg  = 1'b1;
      disp = {{(W-6){1'b0}}, m[5:0]};
    end else begin
      base = sp;
      neg  = 1'b1;
      disp = {{(W-6){1'b0}}, m[5:0]};
    end
  end

  assign addr = (neg ? base - disp : base + disp) + (instr[11] ? xr : '0);
  assign fin  = (code_q ? pb : db) + rd_data;

  function automatic logic out_of(input logic c, input logic [W-1:0] a,
                                  input logic [W-1:0] clo, input logic [W-1:0] chi,
                                  input logic [W-1:0] dlo, input logic [W-1:0] dhi);
    return c ? (a < clo || a > chi) : (a < dlo || a > dhi);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rd_addr  <= '0;
      code_q   <= 1'b0;
      ea       <= '0;
      ea_valid <= 1'b0;
      ea_fault <= 1'b0;
    end else begin
      ea_valid <= 1'b0;
      ea_fault <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          code_q <= code;
          if (instr[10]) begin
            rd_addr <= addr;
            st      <= S_WAIT;
          end else begin
            ea       <= addr;
            ea_valid <= 1'b1;
            ea_fault <= out_of(code, addr, pb, pl, db, sl);
          end
        end
        S_WAIT: if (rd_valid) begin
          ea       <= fin;
          ea_valid <= 1'b1;
          ea_fault <= out_of(code_q, fin, pb, pl, db, sl);
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st == S_WAIT);
  assign rd_req = busy;

  AST_DIRECT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !instr[10] |=> ea_valid && !rd_req); // R7
  AST_IND_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && instr[10] |=> rd_req && !ea_valid); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R8
  AST_DATA_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_valid |=> ea_valid && !rd_req); // R8
  AST_FAULT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    ea_fault |-> ea_valid); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !rd_valid |=> !ea_valid && $stable(rd_addr)); // R11
  AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_valid && !$past(ea_valid) && $past(rst_n) |-> $stable(ea)); // R7

endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, start = 0, rd_valid = 0;
  logic [15:0] instr = '0;
  logic [W-1:0] pc = 16'h1000, pb = 16'h0800, pl = 16'h1FFF, db = 16'h2000,
                sl = 16'h2FFF, q = 16'h2400, sp = 16'h2800, xr = '0, rd_data = '0;
  logic busy, rd_req, ea_valid, ea_fault;
  logic [W-1:0] rd_addr, ea;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  ea_gen #(.W(W)) u_ea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc), .pb(pb),
    .pl(pl), .db(db), .sl(sl), .q(q), .sp(sp), .xr(xr), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .ea_valid(ea_valid), .ea_fault(ea_fault), .ea(ea));

  // {instr, index, expected ea, expected fault}
  localparam logic [48:0] VEC [16] = '{
    {16'h1025, 16'h0000, 16'h1025, 1'b0},
    {16'hF025, 16'h0000, 16'h1025, 1'b0},
    {16'h2180, 16'h0000, 16'h0F80, 1'b0},
    {16'h30FF, 16'h0000, 16'h10FF, 1'b0},
    {16'h427F, 16'h0000, 16'h207F, 1'b0},
    {16'h537F, 16'h0000, 16'h247F, 1'b0},
    {16'h63BF, 16'h0000, 16'h23C1, 1'b0},
    {16'h73D0, 16'h0000, 16'h27F0, 1'b0},
    {16'h8A10, 16'h0100, 16'h2110, 1'b0},
    {16'h0B81, 16'hFFFF, 16'h23FE, 1'b0},
    {16'h0BC0, 16'hF000, 16'h1800, 1'b1},
    {16'h0A00, 16'h1000, 16'h3000, 1'b1},
    {16'h0A00, 16'h0FFF, 16'h2FFF, 1'b0},
    {16'h0800, 16'h1000, 16'h2000, 1'b1},
    {16'h0900, 16'hF800, 16'h0800, 1'b0},
    {16'h0900, 16'hF7FF, 16'h07FF, 1'b1}
  };

  function automatic string vreq(int i);
    case (i)
      0, 2, 3: return "R2";
      1:       return "R1";
      4:       return "R3";
      5, 6:    return "R4";
      7:       return "R5";
      8, 9:    return "R6";
      10, 11, 12: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic direct(string req, logic [15:0] ins, logic [W-1:0] x,
                        logic [W-1:0] exp_ea, logic exp_f);
    @(negedge clk); instr = ins; xr = x; start = 1;
    @(negedge clk); start = 0;
    chk(req, "ea_valid", W'(ea_valid), W'(1));
    chk(req, "ea", ea, exp_ea);
    chk(req, "ea_fault", W'(ea_fault), W'(exp_f));
    @(negedge clk);
    chk("R7", "ea_valid pulse", W'(ea_valid), W'(0));
    chk("R7", "ea hold", ea, exp_ea);
  endtask

  task automatic indirect(string req, logic [15:0] ins, logic [W-1:0] x, logic [W-1:0] exp_rd,
                          logic [W-1:0] data, logic [W-1:0] exp_ea, logic exp_f, bit intrude);
    @(negedge clk); instr = ins; xr = x; start = 1;
    @(negedge clk);
    chk("R8", "rd_req", W'(rd_req), W'(1));
    chk(req, "rd_addr", rd_addr, exp_rd);
    chk("R8", "ea_valid while waiting", W'(ea_valid), W'(0));
    if (intrude) begin instr = 16'h1025; xr = '0; start = 1; end
    else start = 0;
    @(negedge clk); start = 0;
    chk(intrude ? "R11" : "R8", "ea_valid while busy", W'(ea_valid), W'(0));
    chk(intrude ? "R11" : "R8", "rd_addr held", rd_addr, exp_rd);
    @(negedge clk);
    chk("R8", "rd_req held", W'(rd_req), W'(1));
    rd_valid = 1; rd_data = data;
    @(negedge clk); rd_valid = 0;
    chk("R8", "ea_valid after data", W'(ea_valid), W'(1));
    chk(req, "ea", ea, exp_ea);
    chk(req, "ea_fault", W'(ea_fault), W'(exp_f));
    chk("R8", "rd_req dropped", W'(rd_req), W'(0));
    @(negedge clk);
    chk(intrude ? "R11" : "R7", "no extra result", W'(ea_valid), W'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset ea_valid", W'(ea_valid), W'(0));
    chk("R1", "reset rd_req", W'(rd_req), W'(0));
    chk("R1", "reset busy", W'(busy), W'(0));
    chk("R1", "reset ea_fault", W'(ea_fault), W'(0));
    rst_n = 1;
    for (int i = 0; i < 16; i++)
      direct(vreq(i), VEC[i][48:33], VEC[i][32:17], VEC[i][16:1], VEC[i][0]);
    indirect("R8", 16'h0605, 16'h0000, 16'h2005, 16'h0123, 16'h2123, 1'b0, 1'b1);
    indirect("R6", 16'h0C10, 16'h0002, 16'h1012, 16'h0040, 16'h0840, 1'b0, 1'b0);
    indirect("R9", 16'h07C1, 16'h0000, 16'h27FF, 16'h1000, 16'h3000, 1'b1, 1'b0);
    indirect("R10", 16'h0410, 16'h0000, 16'h1010, 16'h1800, 16'h2000, 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule